// File: doc/BRIEF.md
# NAND Parameter-Page Boot Sequencer

This block runs once at power-up and walks an 8-bit NAND flash through the steps needed to load a boot image. It is used when no valid boot header has been found on page 0. In that case it sends an identification probe to check whether the device follows the ONFI standard. If the probe passes, it reads the parameter page and keeps three values: the page size, the spare-area size and the required ECC strength. From these it works out the ECC sector size, and it turns ECC on.

After that, it re-reads page 0. A 16-bit little-endian image length sits at byte offsets 0xD0 and 0xD1, and the image follows from offset 0xD2. Each image byte goes out on a write port to an internal SRAM, starting at address 0. If the caller has already found a valid header, the probe and parameter phases are skipped. The page re-read then uses the ECC setting supplied with the header.

The bus is abstracted as one registered strobe per cycle. `nand_cle` marks a command byte and `nand_ale` marks an address byte, both carried on `nand_dout`. Each `nand_re` cycle requests one data byte, and the device presents that byte on `nand_din` during the following cycle.

Top module: `onfi_boot_seq`

## Requirements
- R1: When `start` is pulsed with `header_ok` high, no probe or parameter read is issued. The first command is the page-read opcode 0x00, and `ecc_en` takes the value of `hdr_ecc_en`.
- R2: When `start` is pulsed with `header_ok` low, the first command is 0x90, followed in the next cycle by a single address byte 0x20. Four data reads follow, and the probe passes only if they return 0x4F, 0x4E, 0x46 and 0x49 in that order.
- R3: A failed probe sets `boot_fail`, leaves `boot_done` low and issues no further bus cycles. `boot_done` and `boot_fail` are never high together.
- R4: After a passing probe, the block sends command 0xEC and then address 0x00. It waits for `nand_rb` to fall and then rise, and then reads exactly 113 bytes (offsets 0 to 112).
- R5: `page_size` is the 32-bit little-endian value at parameter offsets 80 to 83.
- R6: `spare_size` is the 16-bit little-endian value at parameter offsets 84 and 85.
- R7: `ecc_bits` is the byte at parameter offset 112. `ecc_sector_size` is 1024 when that byte is 0xFF and 512 otherwise.
- R8: A successful parameter-page read forces `ecc_en` to 1.
- R9: The page-0 re-read is made of these steps in order:
  - command 0x00;
  - ADDR_CYC address bytes of 0x00 (5 by default);
  - command 0x30;
  - a wait for `nand_rb` to fall and rise before any read.
- R10: The length at offsets 0xD0 (low byte) and 0xD1 (high byte) is valid if it lies in 1..2^SRAM_AW. When it is valid, the bytes from offset 0xD2 onward are written to SRAM at consecutive addresses starting at 0, exactly `length` writes are made, and `boot_done` is then set.
- R11: A length of 0, or one above 2^SRAM_AW, sets `boot_fail`, produces no SRAM write and stops reading after offset 0xD1.
- R12: At most one of `nand_cle`, `nand_ale` and `nand_re` is high in any cycle, and `nand_re` is only asserted while `nand_rb` is high.
- R13: After reset, every output is 0 except `ecc_sector_size`, which is 512. A new `start` clears `boot_done`, `boot_fail` and the captured parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a boot sequence while idle |
| header_ok | input | 1 | A valid boot header was already found on page 0 |
| hdr_ecc_en | input | 1 | ECC request carried by that header |
| nand_cle | output | 1 | Command strobe for the byte on nand_dout |
| nand_ale | output | 1 | Address strobe for the byte on nand_dout |
| nand_re | output | 1 | Read request; the byte arrives on nand_din in the next cycle |
| nand_dout | output | 8 | Command or address byte |
| nand_din | input | 8 | Data byte from the flash |
| nand_rb | input | 1 | Ready (1) / busy (0) from the flash |
| page_size | output | 32 | Bytes per page from the parameter page |
| spare_size | output | 16 | Spare bytes per page from the parameter page |
| ecc_bits | output | 8 | Required correctable bits from the parameter page |
| ecc_sector_size | output | 11 | ECC sector size, 512 or 1024 |
| ecc_en | output | 1 | ECC enable for the page re-read |
| sram_we | output | 1 | SRAM write strobe |
| sram_addr | output | SRAM_AW | SRAM write address |
| sram_wdata | output | 8 | SRAM write data |
| boot_done | output | 1 | Image copied successfully |
| boot_fail | output | 1 | Probe failed or the image length is invalid |

## Verification
The properties rely on the following assumptions about the flash:
- Busy only follows the 0xEC and 0x30 commands.
- `nand_rb` falls within a few cycles of either of those commands and rises again later.
- Outside those windows, `nand_rb` stays high.
- Every read request is answered with a byte one cycle later.
- `start` is only pulsed while the block is idle.

The bench's flash model is built to stay inside these assumptions. It drops ready for a fixed six cycles after each busy-causing command, moves a byte pointer on every read, and resets that pointer on each command. The stimulus raises `start` only after `boot_done` or `boot_fail` has been seen.

// File: rtl/onfi_boot_pkg.sv
package onfi_boot_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ID_CMD, S_ID_ADR, S_PP_CMD, S_PP_ADR,
    S_PG_CMD, S_PG_ADR, S_PG_CFM, S_WLO, S_WHI, S_READ, S_EVAL
  } state_t;

  typedef enum logic [1:0] {PH_ID, PH_PARAM, PH_PAGE} phase_t;

  localparam logic [7:0] OP_READ_ID  = 8'h90;
  localparam logic [7:0] OP_ID_ADDR  = 8'h20;
  localparam logic [7:0] OP_PARAM    = 8'hEC;
  localparam logic [7:0] OP_READ     = 8'h00;
  localparam logic [7:0] OP_CONFIRM  = 8'h30;

  localparam int ID_LEN    = 4;
  localparam int PARAM_LEN = 113;
  localparam int OFS_PAGE  = 80;
  localparam int OFS_SPARE = 84;
  localparam int OFS_ECC   = 112;
  localparam int IMG_OFS   = 208;
  localparam int IMG_BASE  = IMG_OFS + 2;

endpackage

// File: rtl/onfi_param_capture.sv
module onfi_param_capture
  import onfi_boot_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             id_en,
  input  logic             par_en,
  input  logic [CNT_W-1:0] idx,
  input  logic [7:0]       din,
  output logic             sig_ok,
  output logic [31:0]      page_size,
  output logic [15:0]      spare_size,
  output logic [7:0]       ecc_bits,
  output logic [10:0]      ecc_sector_size
);

  localparam int PAGE_BYTES  = 4;
  localparam int SPARE_BYTES = 2;

  logic mism_q;

  function automatic logic [7:0] sig_byte(input logic [1:0] k);
    case (k)
      2'd0:    sig_byte = 8'h4F;
      2'd1:    sig_byte = 8'h4E;
      2'd2:    sig_byte = 8'h46;
      default: sig_byte = 8'h49;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clr)
      mism_q <= 1'b0;
    else if (id_en && (din != sig_byte(idx[1:0])))
      mism_q <= 1'b1;
  end
  assign sig_ok = !mism_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_page
    logic [7:0] b_q;
    always_ff @(posedge clk) begin
      if (rst || clr)
        b_q <= '0;
      else if (par_en && (idx == CNT_W'(OFS_PAGE + g)))
        b_q <= din;
    end
    assign page_size[8*g +: 8] = b_q;
  end

  for (genvar g = 0; g < SPARE_BYTES; g++) begin : g_spare
    logic [7:0] b_q;
    always_ff @(posedge clk) begin
      if (rst || clr)
        b_q <= '0;
      else if (par_en && (idx == CNT_W'(OFS_SPARE + g)))
        b_q <= din;
    end
    assign spare_size[8*g +: 8] = b_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ecc_bits        <= '0;
      ecc_sector_size <= 11'd512;
    end else if (par_en && (idx == CNT_W'(OFS_ECC))) begin
      ecc_bits        <= din;
      ecc_sector_size <= (din == 8'hFF) ? 11'd1024 : 11'd512;
    end
  end

endmodule

// File: rtl/onfi_image_copy.sv
module onfi_image_copy
  import onfi_boot_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SRAM_AW = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               en,
  input  logic [CNT_W-1:0]   idx,
  input  logic [7:0]         din,
  output logic               hdr_seen,
  output logic [15:0]        img_len,
  output logic               img_ok,
  output logic               sram_we,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [7:0]         sram_wdata
);

  localparam int MAX_LEN = 1 << SRAM_AW;
  localparam logic [CNT_W-1:0] LEN_LO_C = CNT_W'(IMG_OFS);
  localparam logic [CNT_W-1:0] LEN_HI_C = CNT_W'(IMG_OFS + 1);
  localparam logic [CNT_W-1:0] BASE_C   = CNT_W'(IMG_BASE);

  logic [7:0] len_lo_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      len_lo_q <= '0;
      img_len  <= '0;
      hdr_seen <= 1'b0;
    end else if (en) begin
      if (idx == LEN_LO_C)
        len_lo_q <= din;
      if (idx == LEN_HI_C) begin
        img_len  <= {din, len_lo_q};
        hdr_seen <= 1'b1;
      end
    end
  end

  assign img_ok = hdr_seen && (img_len != '0) && (32'(img_len) <= 32'(MAX_LEN));

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_we    <= 1'b0;
      sram_addr  <= '0;
      sram_wdata <= '0;
    end else begin
      sram_we <= 1'b0;
      if (en && img_ok && (idx >= BASE_C)) begin
        sram_we    <= 1'b1;
        sram_addr  <= SRAM_AW'(idx - BASE_C);
        sram_wdata <= din;
      end
    end
  end

endmodule

// File: rtl/onfi_boot_seq.sv
module onfi_boot_seq
  import onfi_boot_pkg::*;
#(
  parameter int ADDR_CYC = 5,
  parameter int SRAM_AW  = 10,
  parameter int CNT_W    = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               header_ok,
  input  logic               hdr_ecc_en,
  output logic               nand_cle,
  output logic               nand_ale,
  output logic               nand_re,
  output logic [7:0]         nand_dout,
  input  logic [7:0]         nand_din,
  input  logic               nand_rb,
  output logic [31:0]        page_size,
  output logic [15:0]        spare_size,
  output logic [7:0]         ecc_bits,
  output logic [10:0]        ecc_sector_size,
  output logic               ecc_en,
  output logic               sram_we,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [7:0]         sram_wdata,
  output logic               boot_done,
  output logic               boot_fail
);

  localparam int AC_W = $clog2(ADDR_CYC + 1);

  state_t           state;
  phase_t           phase;
  logic [CNT_W-1:0] issued, cap_cnt, rd_total, lim;
  logic [AC_W-1:0]  acnt;
  logic             rd_vld, clr, sig_ok, hdr_seen, img_ok, rd_done;
  logic [15:0]      img_len;

  assign clr = (state == S_IDLE) && start;

  onfi_param_capture #(.CNT_W(CNT_W)) param_i (
    .clk(clk), .rst(rst), .clr(clr),
    .id_en(rd_vld && (phase == PH_ID)),
    .par_en(rd_vld && (phase == PH_PARAM)),
    .idx(cap_cnt), .din(nand_din), .sig_ok(sig_ok),
    .page_size(page_size), .spare_size(spare_size),
    .ecc_bits(ecc_bits), .ecc_sector_size(ecc_sector_size)
  );

  onfi_image_copy #(.CNT_W(CNT_W), .SRAM_AW(SRAM_AW)) copy_i (
    .clk(clk), .rst(rst), .clr(clr),
    .en(rd_vld && (phase == PH_PAGE)),
    .idx(cap_cnt), .din(nand_din),
    .hdr_seen(hdr_seen), .img_len(img_len), .img_ok(img_ok),
    .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata)
  );

  always_comb begin
    lim = rd_total;
    if ((phase == PH_PAGE) && img_ok)
      lim = CNT_W'(IMG_BASE) + CNT_W'(img_len);
  end

  assign rd_done = (cap_cnt == lim) && ((phase != PH_PAGE) || hdr_seen);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      phase     <= PH_ID;
      nand_cle  <= 1'b0;
      nand_ale  <= 1'b0;
      nand_re   <= 1'b0;
      nand_dout <= '0;
      rd_vld    <= 1'b0;
      issued    <= '0;
      cap_cnt   <= '0;
      rd_total  <= '0;
      acnt      <= '0;
      ecc_en    <= 1'b0;
      boot_done <= 1'b0;
      boot_fail <= 1'b0;
    end else begin
      nand_cle <= 1'b0;
      nand_ale <= 1'b0;
      nand_re  <= 1'b0;
      rd_vld   <= nand_re;
      if (rd_vld)
        cap_cnt <= cap_cnt + 1'b1;
      case (state)
        S_IDLE: if (start) begin
          boot_done <= 1'b0;
          boot_fail <= 1'b0;
          ecc_en    <= header_ok ? hdr_ecc_en : 1'b0;
          state     <= header_ok ? S_PG_CMD : S_ID_CMD;
        end
        S_ID_CMD: begin
          nand_cle  <= 1'b1;
          nand_dout <= OP_READ_ID;
          state     <= S_ID_ADR;
        end
        S_ID_ADR: begin
          nand_ale  <= 1'b1;
          nand_dout <= OP_ID_ADDR;
          phase     <= PH_ID;
          rd_total  <= CNT_W'(ID_LEN);
          issued    <= '0;
          cap_cnt   <= '0;
          state     <= S_READ;
        end
        S_PP_CMD: begin
          nand_cle  <= 1'b1;
          nand_dout <= OP_PARAM;
          state     <= S_PP_ADR;
        end
        S_PP_ADR: begin
          nand_ale  <= 1'b1;
          nand_dout <= 8'h00;
          phase     <= PH_PARAM;
          rd_total  <= CNT_W'(PARAM_LEN);
          issued    <= '0;
          cap_cnt   <= '0;
          state     <= S_WLO;
        end
        S_PG_CMD: begin
          nand_cle  <= 1'b1;
          nand_dout <= OP_READ;
          acnt      <= '0;
          state     <= S_PG_ADR;
        end
        S_PG_ADR: begin
          nand_ale  <= 1'b1;
          nand_dout <= 8'h00;
          acnt      <= acnt + 1'b1;
          if (acnt == AC_W'(ADDR_CYC - 1))
            state <= S_PG_CFM;
        end
        S_PG_CFM: begin
          nand_cle  <= 1'b1;
          nand_dout <= OP_CONFIRM;
          phase     <= PH_PAGE;
          rd_total  <= CNT_W'(IMG_BASE);
          issued    <= '0;
          cap_cnt   <= '0;
          state     <= S_WLO;
        end
        S_WLO: if (!nand_rb) state <= S_WHI;
        S_WHI: if (nand_rb)  state <= S_READ;
        S_READ: begin
          if (issued < lim) begin
            nand_re <= 1'b1;
            issued  <= issued + 1'b1;
          end else if (rd_done) begin
            state <= S_EVAL;
          end
        end
        S_EVAL: begin
          case (phase)
            PH_ID: begin
              if (sig_ok) state <= S_PP_CMD;
              else begin
                boot_fail <= 1'b1;
                state     <= S_IDLE;
              end
            end
            PH_PARAM: begin
              ecc_en <= 1'b1;
              state  <= S_PG_CMD;
            end
            default: begin
              if (img_ok) boot_done <= 1'b1;
              else        boot_fail <= 1'b1;
              state <= S_IDLE;
            end
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/onfi_boot_seq_chk.sv
module onfi_boot_seq_chk #(
  parameter int SRAM_AW = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               nand_cle,
  input logic               nand_ale,
  input logic               nand_re,
  input logic [7:0]         nand_dout,
  input logic               nand_rb,
  input logic [10:0]        ecc_sector_size,
  input logic               sram_we,
  input logic [SRAM_AW-1:0] sram_addr,
  input logic               boot_done,
  input logic               boot_fail
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({nand_cle, nand_ale, nand_re})); // R12

  AST_READ_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
    nand_re |-> nand_rb); // R12

  AST_PROBE_ADDR: assert property (@(posedge clk) disable iff (rst)
    (nand_cle && nand_dout == 8'h90) |=> (nand_ale && nand_dout == 8'h20)); // R2

  AST_CONFIRM_AFTER_ADDR: assert property (@(posedge clk) disable iff (rst)
    (nand_cle && nand_dout == 8'h30) |-> $past(nand_ale)); // R9

  AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(boot_done && boot_fail)); // R3

  AST_SECTOR_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (ecc_sector_size == 11'd512) || (ecc_sector_size == 11'd1024)); // R7

  AST_SRAM_FIRST_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we) |-> (sram_addr == '0)); // R10

  AST_SRAM_CONSEC: assert property (@(posedge clk) disable iff (rst)
    (sram_we && $past(sram_we)) |-> (sram_addr == SRAM_AW'($past(sram_addr) + 1'b1))); // R10

  AST_NO_WRITE_ON_FAIL: assert property (@(posedge clk) disable iff (rst)
    boot_fail |-> !sram_we); // R11

endmodule

bind onfi_boot_seq onfi_boot_seq_chk #(.SRAM_AW(SRAM_AW)) chk_i (
  .clk(clk), .rst(rst), .nand_cle(nand_cle), .nand_ale(nand_ale),
  .nand_re(nand_re), .nand_dout(nand_dout), .nand_rb(nand_rb),
  .ecc_sector_size(ecc_sector_size), .sram_we(sram_we), .sram_addr(sram_addr),
  .boot_done(boot_done), .boot_fail(boot_fail)
);

// File: tb/onfi_boot_seq_tb_top.sv
`timescale 1ns/1ps
module onfi_boot_seq_tb_top;

  localparam int AW   = 10;
  localparam int MAXL = 1 << AW;
  localparam int PGB  = 210 + MAXL + 4;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, header_ok = 1'b0, hdr_ecc_en = 1'b0;
  logic nand_cle, nand_ale, nand_re, nand_rb;
  logic [7:0] nand_dout, nand_din;
  logic [31:0] page_size;
  logic [15:0] spare_size;
  logic [7:0] ecc_bits;
  logic [10:0] ecc_sector_size;
  logic ecc_en, sram_we, boot_done, boot_fail;
  logic [AW-1:0] sram_addr;
  logic [7:0] sram_wdata;

  always #2.5 clk = ~clk;

  onfi_boot_seq #(.SRAM_AW(AW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .header_ok(header_ok), .hdr_ecc_en(hdr_ecc_en),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_re(nand_re), .nand_dout(nand_dout),
    .nand_din(nand_din), .nand_rb(nand_rb), .page_size(page_size), .spare_size(spare_size),
    .ecc_bits(ecc_bits), .ecc_sector_size(ecc_sector_size), .ecc_en(ecc_en),
    .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
    .boot_done(boot_done), .boot_fail(boot_fail)
  );

  // flash model
  logic [7:0] id_mem [4];
  logic [7:0] par_mem [128];
  logic [7:0] pg_mem [PGB];
  logic [7:0] sram_mem [MAXL];
  logic [7:0] log_b [32];
  logic       log_a [32];
  logic dev_clr = 1'b0;
  int mode, ptr, busy, log_n, bad_reads, par_reads, pg_reads, wr_cnt;

  assign nand_rb = (busy == 0);

  always @(posedge clk) begin
    if (dev_clr) begin
      mode <= 0; ptr <= 0; busy <= 0; log_n <= 0;
      bad_reads <= 0; par_reads <= 0; pg_reads <= 0; wr_cnt <= 0;
      nand_din <= 8'h00;
    end else begin
      if (nand_cle || nand_ale) begin
        if (log_n < 32) begin
          log_b[log_n] <= nand_dout;
          log_a[log_n] <= nand_ale;
        end
        log_n <= log_n + 1;
      end
      if (nand_cle) begin
        ptr <= 0;
        case (nand_dout)
          8'h90: mode <= 1;
          8'hEC: begin mode <= 2; busy <= 6; end
          8'h30: begin mode <= 3; busy <= 6; end
          default: ;
        endcase
      end else if (busy > 0) begin
        busy <= busy - 1;
      end
      if (nand_re) begin
        if (!nand_rb) bad_reads <= bad_reads + 1;
        ptr <= ptr + 1;
        case (mode)
          1: nand_din <= id_mem[ptr % 4];
          2: begin nand_din <= par_mem[ptr % 128]; par_reads <= par_reads + 1; end
          3: begin nand_din <= (ptr < PGB) ? pg_mem[ptr] : 8'hEE; pg_reads <= pg_reads + 1; end
          default: nand_din <= 8'h00;
        endcase
      end
      if (sram_we) begin
        sram_mem[sram_addr] <= sram_wdata;
        wr_cnt <= wr_cnt + 1;
      end
    end
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int v, input int k);
    return 8'((k * 13 + v * 5 + 1) & 255);
  endfunction

  typedef struct packed {
    logic        hdr;
    logic        hecc;
    logic        sig;
    logic [31:0] psz;
    logic [15:0] spr;
    logic [7:0]  ecc;
    logic [15:0] len;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 1'b1, 32'd2048,     16'd64,     8'd8,   16'd16},
    '{1'b0, 1'b0, 1'b1, 32'd4096,     16'd224,    8'hFF,  16'd37},
    '{1'b0, 1'b0, 1'b0, 32'd2048,     16'd64,     8'd4,   16'd8},
    '{1'b1, 1'b1, 1'b1, 32'd0,        16'd0,      8'd0,   16'd5},
    '{1'b1, 1'b0, 1'b0, 32'd0,        16'd0,      8'd0,   16'd1},
    '{1'b0, 1'b0, 1'b1, 32'h0001_2345, 16'h1234,  8'hFE,  16'd1024},
    '{1'b0, 1'b0, 1'b1, 32'd8192,     16'd448,    8'd24,  16'd0},
    '{1'b1, 1'b0, 1'b1, 32'd0,        16'd0,      8'd0,   16'd1025}
  };

  task automatic load(input vec_t v, input int vi);
    id_mem[0] = 8'h4F; id_mem[1] = 8'h4E; id_mem[2] = 8'h46;
    id_mem[3] = v.sig ? 8'h49 : 8'h4A;
    for (int i = 0; i < 128; i++) par_mem[i] = 8'(8'hA5 ^ i);
    for (int i = 0; i < 4; i++) par_mem[80 + i] = v.psz[8*i +: 8];
    par_mem[84] = v.spr[7:0]; par_mem[85] = v.spr[15:8];
    par_mem[112] = v.ecc;
    for (int i = 0; i < 208; i++) pg_mem[i] = 8'h5A;
    pg_mem[208] = v.len[7:0]; pg_mem[209] = v.len[15:8];
    for (int i = 210; i < PGB; i++) pg_mem[i] = pat(vi, i - 210);
    @(negedge clk); dev_clr = 1'b1;
    @(negedge clk); dev_clr = 1'b0;
  endtask

  task automatic wait_end(input string tag);
    int cyc = 0;
    while (!(boot_done || boot_fail) && cyc < 6000) begin
      @(negedge clk); cyc++;
    end
    if (cyc >= 6000) begin
      n_chk++; n_bad++;
      $display("FAIL %s timeout: actual=busy expected=finished", tag);
    end
  endtask

  task automatic run_vec(input vec_t v, input int vi);
    bit probe, pfail, lbad, ok;
    int exp_wr, mism;
    load(v, vi);
    header_ok = v.hdr; hdr_ecc_en = v.hecc;
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_end("R10");
    probe = !v.hdr;
    pfail = probe && !v.sig;
    lbad  = !pfail && (v.len == 0 || v.len > MAXL);
    ok    = !pfail && !lbad;
    exp_wr = ok ? int'(v.len) : 0;
    chk("R10", "boot_done", 32'(boot_done), 32'(ok));
    chk("R3",  "boot_fail", 32'(boot_fail), 32'(!ok));
    chk("R5",  "page_size", page_size, (probe && v.sig) ? v.psz : 32'd0);
    chk("R6",  "spare_size", 32'(spare_size), (probe && v.sig) ? 32'(v.spr) : 32'd0);
    chk("R7",  "ecc_bits", 32'(ecc_bits), (probe && v.sig) ? 32'(v.ecc) : 32'd0);
    chk("R7",  "sector", 32'(ecc_sector_size), (probe && v.sig && v.ecc == 8'hFF) ? 32'd1024 : 32'd512);
    if (probe) chk("R8", "ecc_en onfi", 32'(ecc_en), 32'(v.sig));
    else       chk("R1", "ecc_en header", 32'(ecc_en), 32'(v.hecc));
    chk("R1",  "first cmd", 32'(log_b[0]), probe ? 32'h90 : 32'h00);
    chk("R12", "reads while busy", 32'(bad_reads), 32'd0);
    if (pfail) chk("R3", "bus cycles after bad probe", 32'(log_n), 32'd2);
    else chk("R9", "cmd/addr count", 32'(log_n), probe ? 32'd11 : 32'd7);
    chk("R4", "param reads", 32'(par_reads), (probe && v.sig) ? 32'd113 : 32'd0);
    if (probe && v.sig) begin
      chk("R2", "probe addr", 32'({log_a[1], log_b[1]}), 32'h120);
      chk("R4", "param cmd", 32'({log_a[2], log_b[2]}), 32'h0EC);
      chk("R9", "confirm", 32'({log_a[10], log_b[10]}), 32'h030);
      chk("R9", "addr cycles", 32'(log_a[5] + log_a[6] + log_a[7] + log_a[8] + log_a[9]), 32'd5);
    end
    chk("R11", "sram writes", 32'(wr_cnt), 32'(exp_wr));
    if (!pfail) chk("R11", "page reads", 32'(pg_reads), ok ? 32'(210 + exp_wr) : 32'd210);
    mism = 0;
    for (int k = 0; k < exp_wr; k++) if (sram_mem[k] !== pat(vi, k)) mism++;
    chk("R10", "sram content mismatches", 32'(mism), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13: reset state
    chk("R13", "outputs after reset",
        32'({nand_cle, nand_ale, nand_re, sram_we, ecc_en, boot_done, boot_fail}), 32'd0);
    chk("R13", "params after reset", page_size | 32'(spare_size) | 32'(ecc_bits), 32'd0);
    chk("R13", "sector after reset", 32'(ecc_sector_size), 32'd512);

    for (int i = 0; i < 8; i++) run_vec(VECS[i], i);

    // R13: restart after a failure clears flags and captured parameters
    run_vec(VECS[2], 2);
    load(VECS[0], 0);
    header_ok = 1'b0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk("R13", "flags cleared by start", 32'({boot_done, boot_fail}), 32'd0);
    wait_end("R13");
    chk("R13", "rerun done", 32'(boot_done), 32'd1);
    chk("R5",  "rerun page_size", page_size, 32'd2048);

    // R1: header path after an ONFI run resets parameters to defaults
    run_vec(VECS[3], 3);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule